// File: doc/BRIEF.md
# Three-Channel Tone and Noise Sound Generator

This block produces three square-wave voices and one shared pseudo-random noise stream. It mixes them into a right and a left level. A host programs it through a byte-wide write port. Each voice has a 12-bit period and a 2-bit volume. Each voice can also take its level from an external envelope input. A control byte picks one of four waveform modes for each voice: constant high, square, noise, or noise let through only while the square is high.

A free-running prescaler divides the system clock by 32. Each prescaler tick advances the period counters and the noise timer. Voice 0 is routed to the right output, voice 1 to the left output, and voice 2 to both outputs. The envelope generator lives in another block and supplies its level on `envLevel`.

Top module: `tone_noise_gen`

## Requirements
- R1: While `rstN` is low and right after reset, both outputs are 0. After reset all registers are cleared and the noise register holds the seed 1.
- R2: A tick occurs once every 32 clocks. For a period P of 2 or more, a voice's square flips after every P ticks.
- R3: A period of 0 keeps the voice low in every mode. A period of 1 holds the square permanently high.
- R4: Period registers sit at addresses 2c (bits 7:0) and 2c+1 (data bits 3:0 go to period bits 11:8; data bits 7:4 are dropped), for voice c = 0..2.
- R5: Noise comes from a 17-bit shift register. It shifts left, the new bit 0 is bit16 XOR bit13, and the noise level is the inverse of bit 16.
- R6: Address 6 bits 4:0 hold the noise rate N. The register shifts once every N+1 ticks, so N = 0 shifts on every tick.
- R7: Address 7 control byte: for voice c, mode = {bit c+3, bit c}. The encodings are 11 = constant high, 10 = square, 01 = noise, 00 = noise AND square.
- R8: Addresses 8..10 set the volumes of voices 0..2, with level in bits 1:0. When bit 4 is set, the 4-bit `envLevel` replaces the level.
- R9: `rightOut` = level of voice 0 + level of voice 2, and `leftOut` = level of voice 1 + level of voice 2. A voice adds its level only while its gated waveform is high.
- R10: Writes to addresses 11..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| envLevel | input | 4 | Envelope level from the external envelope block |
| rightOut | output | 5 | Right mixed level |
| leftOut | output | 5 | Left mixed level |

## Verification
Voice 0 is first driven alone as a square with a short period. This separates the tick spacing and the toggle interval from everything else. The noise and gated-noise modes then run at several rates, so a wrong feedback tap, a wrong output polarity or an off-by-one rate count shows up as a different bit pattern. Fixed-level cases check the routing sums, the envelope override and period 0 and 1 directly against hand-computed values. A long run with a period above 255, plus writes to unused addresses, tells a correct high-nibble split apart from one that keeps the wrong bits or decodes stray addresses.

// File: rtl/tone_noise_pkg.sv
package tone_noise_pkg;
  parameter int NCH      = 3;
  parameter int PER_W    = 12;
  parameter int RATE_W   = 5;
  parameter int LVL_W    = 4;
  parameter int VOL_W    = 2;
  parameter int LFSR_W   = 17;
  parameter int LFSR_TAP = 13;
  parameter int PRESCALE = 32;
  parameter int ADDR_W   = 4;
  parameter int DATA_W   = 8;
  parameter int ENV_BIT  = 4;

  localparam int OUT_W     = LVL_W + 1;
  localparam int PRE_W     = $clog2(PRESCALE);
  localparam int RATE_ADDR = 2 * NCH;
  localparam int CTL_ADDR  = 2 * NCH + 1;
  localparam int VOL_BASE  = 2 * NCH + 2;
  localparam int RIGHT_CH  = 0;
  localparam int LEFT_CH   = 1;
  localparam int BOTH_CH   = 2;

  typedef struct packed {
    logic tick;
    logic noiseStep;
  } sndStrobe_t;

  typedef struct packed {
    logic [NCH-1:0][PER_W-1:0] period;
    logic [RATE_W-1:0]         noiseRate;
    logic [2*NCH-1:0]          modeBits;
    logic [NCH-1:0]            envSel;
    logic [NCH-1:0][VOL_W-1:0] volume;
  } sndRegs_t;

  typedef enum logic [1:0] {
    MODE_GATED  = 2'b00,
    MODE_NOISE  = 2'b01,
    MODE_SQUARE = 2'b10,
    MODE_HIGH   = 2'b11
  } chMode_t;
endpackage

// File: rtl/tone_noise_ctrl.sv
module tone_noise_ctrl
  import tone_noise_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output sndRegs_t          regs,
  output sndStrobe_t        strb
);
  logic [PRE_W-1:0]  preCnt;
  logic [RATE_W-1:0] noiseCnt;
  logic              tickNow;
  logic              stepNow;

  assign tickNow = (preCnt == PRE_W'(PRESCALE - 1));
  assign stepNow = tickNow && (noiseCnt >= regs.noiseRate);
  assign strb.tick      = tickNow;
  assign strb.noiseStep = stepNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      noiseCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
      if (tickNow) begin
        if (stepNow) noiseCnt <= '0;
        else         noiseCnt <= noiseCnt + RATE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else if (wrEn) begin
      for (int c = 0; c < NCH; c++) begin
        if (wrAddr == ADDR_W'(2 * c))
          regs.period[c][DATA_W-1:0] <= wrData;
        if (wrAddr == ADDR_W'(2 * c + 1))
          regs.period[c][PER_W-1:DATA_W] <= wrData[PER_W-DATA_W-1:0];
        if (wrAddr == ADDR_W'(VOL_BASE + c)) begin
          regs.envSel[c] <= wrData[ENV_BIT];
          regs.volume[c] <= wrData[VOL_W-1:0];
        end
      end
      if (wrAddr == ADDR_W'(RATE_ADDR)) regs.noiseRate <= wrData[RATE_W-1:0];
      if (wrAddr == ADDR_W'(CTL_ADDR))  regs.modeBits  <= wrData[2*NCH-1:0];
    end
  end
endmodule

// File: rtl/tone_noise_datapath.sv
module tone_noise_datapath
  import tone_noise_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sndRegs_t          regs,
  input  sndStrobe_t        strb,
  input  logic [LVL_W-1:0]  envLevel,
  output logic [LFSR_W-1:0] lfsrState,
  output logic [OUT_W-1:0]  rightOut,
  output logic [OUT_W-1:0]  leftOut
);
  logic                       noiseBit;
  logic [NCH-1:0][LVL_W-1:0]  contrib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lfsrState <= LFSR_W'(1);
    else if (strb.noiseStep) lfsrState <= {lfsrState[LFSR_W-2:0],
                                           lfsrState[LFSR_W-1] ^ lfsrState[LFSR_TAP]};
  end
  assign noiseBit = ~lfsrState[LFSR_W-1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PER_W-1:0] cnt;
    logic             sq;
    logic             sqWave;
    logic             wave;
    logic             silent;
    logic [LVL_W-1:0] level;
    chMode_t          mode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
        sq  <= 1'b0;
      end else if (strb.tick) begin
        if (regs.period[c] < PER_W'(2)) begin
          cnt <= '0;
        end else if (cnt >= regs.period[c] - PER_W'(1)) begin
          cnt <= '0;
          sq  <= ~sq;
        end else begin
          cnt <= cnt + PER_W'(1);
        end
      end
    end

    assign silent = (regs.period[c] == '0);
    assign sqWave = (regs.period[c] == PER_W'(1)) ? 1'b1 : sq;
    assign mode   = chMode_t'({regs.modeBits[NCH + c], regs.modeBits[c]});

    always_comb begin
      unique case (mode)
        MODE_HIGH:   wave = 1'b1;
        MODE_SQUARE: wave = sqWave;
        MODE_NOISE:  wave = noiseBit;
        default:     wave = noiseBit & sqWave;
      endcase
    end

    assign level      = regs.envSel[c] ? envLevel : LVL_W'(regs.volume[c]);
    assign contrib[c] = (!silent && wave) ? level : '0;
  end

  assign rightOut = OUT_W'(contrib[RIGHT_CH]) + OUT_W'(contrib[BOTH_CH]);
  assign leftOut  = OUT_W'(contrib[LEFT_CH])  + OUT_W'(contrib[BOTH_CH]);
endmodule

// File: rtl/tone_noise_gen.sv
module tone_noise_gen
  import tone_noise_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LVL_W-1:0]  envLevel,
  output logic [OUT_W-1:0]  rightOut,
  output logic [OUT_W-1:0]  leftOut
);
  sndRegs_t          regs;
  sndStrobe_t        strb;
  logic [LFSR_W-1:0] lfsrState;

  tone_noise_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .regs(regs), .strb(strb)
  );

  tone_noise_datapath dpI (
    .clk(clk), .rstN(rstN), .regs(regs), .strb(strb),
    .envLevel(envLevel), .lfsrState(lfsrState),
    .rightOut(rightOut), .leftOut(leftOut)
  );
endmodule

// File: rtl/tone_noise_chk.sv
module tone_noise_chk
  import tone_noise_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input sndRegs_t          regs,
  input sndStrobe_t        strb,
  input logic [LFSR_W-1:0] lfsrState,
  input logic [OUT_W-1:0]  rightOut,
  input logic [OUT_W-1:0]  leftOut
);
  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> !strb.tick);

  // R6
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.noiseStep |-> strb.tick);

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0);

  // R5
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.noiseStep |=> $stable(lfsrState));

  // R10
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr >= ADDR_W'(VOL_BASE + NCH)) |=> $stable(regs));

  // R3
  all_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regs.period == '0) |-> (rightOut == '0 && leftOut == '0));
endmodule

bind tone_noise_gen tone_noise_chk chkI (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .regs(regs),
  .strb(strb), .lfsrState(lfsrState), .rightOut(rightOut), .leftOut(leftOut)
);

// File: tb/tb_tone_noise_gen.sv
module tb_tone_noise_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] envLevel = '0;
  logic [4:0] rightOut;
  logic [4:0] leftOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 1'b0;

  tone_noise_gen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .envLevel(envLevel), .rightOut(rightOut), .leftOut(leftOut)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int mPer[3], mCnt[3], mSq[3], mVol[3];
  int mPre = 0, mNcnt = 0, mRate = 0, mCtl = 0, mLfsr = 1;

  function automatic int chLevel(int c);
    int md, sqw, nz, w, lv;
    md  = (((mCtl >> (c + 3)) & 1) << 1) | ((mCtl >> c) & 1);
    sqw = (mPer[c] == 1) ? 1 : mSq[c];
    nz  = ((mLfsr >> 16) & 1) ^ 1;
    case (md)
      3: w = 1;
      2: w = sqw;
      1: w = nz;
      default: w = nz & sqw;
    endcase
    lv = ((mVol[c] >> 4) & 1) ? int'(envLevel) : (mVol[c] & 3);
    return (mPer[c] != 0 && w != 0) ? lv : 0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin mPer[c] = 0; mCnt[c] = 0; mSq[c] = 0; mVol[c] = 0; end
      mPre = 0; mNcnt = 0; mRate = 0; mCtl = 0; mLfsr = 1;
    end else begin
      bit tk, st;
      tk = (mPre == 31);
      st = tk && (mNcnt >= mRate);
      mPre = (mPre + 1) % 32;
      if (tk) mNcnt = st ? 0 : mNcnt + 1;
      if (st) mLfsr = ((mLfsr << 1) & 'h1FFFF) | (((mLfsr >> 16) ^ (mLfsr >> 13)) & 1);
      for (int c = 0; c < 3; c++) begin
        if (tk) begin
          if (mPer[c] < 2) mCnt[c] = 0;
          else if (mCnt[c] >= mPer[c] - 1) begin mCnt[c] = 0; mSq[c] ^= 1; end
          else mCnt[c]++;
        end
      end
      if (wrEn) begin
        for (int c = 0; c < 3; c++) begin
          if (int'(wrAddr) == 2 * c)     mPer[c] = (mPer[c] & 'hF00) | int'(wrData);
          if (int'(wrAddr) == 2 * c + 1) mPer[c] = (mPer[c] & 'h0FF) | ((int'(wrData) & 'hF) << 8);
          if (int'(wrAddr) == 8 + c)     mVol[c] = int'(wrData) & 'h13;
        end
        if (wrAddr == 4'd6) mRate = int'(wrData) & 'h1F;
        if (wrAddr == 4'd7) mCtl  = int'(wrData) & 'h3F;
      end
    end
    #5;
    if (!done) begin
      check(curReq, int'(rightOut), chLevel(0) + chLevel(2), "model rightOut");
      check(curReq, int'(leftOut),  chLevel(1) + chLevel(2), "model leftOut");
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1 reset state
    idle(3);
    #1 check("R1", int'(rightOut), 0, "rightOut in reset");
    check("R1", int'(leftOut), 0, "leftOut in reset");
    rstN = 1'b1;
    idle(40);
    #1 check("R1", int'(rightOut), 0, "rightOut after reset");

    // R3 period 1 constant high under square mode
    curReq = "R3";
    wr(8, 'h02); wr(0, 1); wr(7, 'h08);
    idle(70);
    #1 check("R3", int'(rightOut), 2, "period 1 square");
    check("R9", int'(leftOut), 0, "voice0 not on left");
    // R3 period 0 silent even in constant-high mode
    wr(7, 'h09); wr(0, 0);
    idle(5);
    #1 check("R3", int'(rightOut), 0, "period 0 silent");

    // R8 envelope takes priority
    curReq = "R8";
    wr(0, 1); wr(8, 'h13); envLevel = 4'd9;
    idle(2);
    #1 check("R8", int'(rightOut), 9, "envelope override");

    // R9 routing of voice 2 to both sides
    curReq = "R9";
    wr(4, 1); wr(10, 'h01); wr(7, 'h2D);
    idle(2);
    #1 check("R9", int'(rightOut), 10, "right sum");
    check("R9", int'(leftOut), 1, "left sum");

    // R10 stray addresses ignored
    curReq = "R10";
    for (int a = 11; a < 16; a++) wr(a, 'hFF);
    idle(2);
    #1 check("R10", int'(rightOut), 10, "right after stray writes");
    check("R10", int'(leftOut), 1, "left after stray writes");

    // R4 high nibble split, upper data bits dropped
    curReq = "R4";
    wr(0, 0); wr(1, 'hF0);
    idle(2);
    #1 check("R4", int'(rightOut), 1, "upper data nibble dropped");
    wr(1, 'h01);
    idle(2);
    #1 check("R4", int'(rightOut), 10, "period 0x100 audible");

    // R2 square toggling, voice 0 alone
    curReq = "R2";
    envLevel = 4'd0;
    wr(4, 0); wr(2, 0); wr(8, 3); wr(1, 0); wr(0, 3); wr(7, 'h08);
    idle(1500);
    wr(0, 2);
    idle(800);

    // R7 gated noise and all mode mixes
    curReq = "R7";
    wr(6, 2); wr(0, 5); wr(7, 'h00);
    idle(4000);
    wr(2, 3); wr(9, 2); wr(4, 4); wr(10, 1); wr(7, 'h1A);
    idle(3000);
    wr(7, 'h25);
    idle(3000);

    // R5 pure noise at fastest rate
    curReq = "R5";
    wr(7, 'h01); wr(6, 0);
    idle(5000);

    // R6 slowest and mid noise rates
    curReq = "R6";
    wr(6, 31);
    idle(6000);
    wr(6, 7);
    idle(3000);

    // R8 envelope changing over time
    curReq = "R8";
    wr(8, 'h10); wr(7, 'h08); wr(0, 3);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); envLevel = 4'((i * 7 + 3) % 16);
      idle(60);
    end

    // R9 all three voices
    curReq = "R9";
    wr(0, 2); wr(2, 3); wr(4, 4); wr(8, 3); wr(9, 2); wr(10, 'h11);
    wr(7, 'h38);
    idle(4000);
    wr(7, 'h30);
    idle(3000);

    // R4 long period with high nibble
    curReq = "R4";
    wr(7, 'h08); wr(1, 'h12); wr(0, 'h03);
    idle(36000);

    // R10 stray writes while running
    curReq = "R10";
    for (int a = 11; a < 16; a++) begin wr(a, 'h5A); idle(100); end

    finishRun();
  end
endmodule